// File: doc/BRIEF.md
# Endpoint Control Set/Clear Bank

This block holds the per-endpoint control flags of a USB device controller for ten endpoints. Each endpoint has four flags: a STALL request, a data-toggle reset, a NYET suppression flag and a flag that pauses DMA when an endpoint interrupt occurs. Software never writes a flag directly. It writes ones on a set port to raise flags, and it writes ones on a clear port to drop them. A read-only mask view returns the flags of one selected endpoint.

Protocol events also act on the flags. A received SETUP packet on an endpoint drops that endpoint's STALL request. The toggle-reset flag is never held. A set write to it produces a single-cycle pulse toward the endpoint's data-toggle tracker, which makes the next IN or OUT packet use DATA0. The flag always reads back as zero.

Packet engines, handshake generation and the bus fabric are outside the block. They reach it only through the SETUP strobes, and they use its flag outputs.

Top module: `ep_ctl_bank`

## Requirements
- R1: After reset, every flag output, every toggle pulse and every bit of the mask view is zero.
- R2: A set write with bit 19 of the set data high raises the STALL request of the addressed endpoint on the next clock edge. No other endpoint changes.
- R3: A clear write with bit 19 of the clear data high drops the STALL request of the addressed endpoint on the next clock edge.
- R4: A SETUP strobe for an endpoint drops its STALL request on the next edge. It also wins over a STALL set write to that endpoint in the same cycle.
- R5: A set write with bit 18 high gives exactly one cycle of toggle pulse for the addressed endpoint, starting after the write edge. Bit 18 of the mask view always reads zero.
- R6: Bit 17 on the set or clear port raises or drops NYET suppression for the addressed endpoint.
- R7: Bit 16 on the set or clear port raises or drops DMA-pause-on-interrupt for the addressed endpoint.
- R8: When a set write and a clear write hit the same bit of the same endpoint in one cycle, the clear wins: the flag ends at zero and no toggle pulse is issued.
- R9: Zero bits in the set or clear data, and all bits other than 19 to 16, have no effect. Mask view bits outside 19 to 16 read zero.
- R10: A write whose endpoint index is 10 or more changes no endpoint. Reading such an index returns zero.
- R11: The mask view returns the selected endpoint's flags with STALL request at bit 19, toggle reset at bit 18, NYET suppression at bit 17 and DMA pause at bit 16.
- R12: A SETUP strobe leaves NYET suppression and DMA pause unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_we | input | 1 | Set-port write strobe |
| clr_we | input | 1 | Clear-port write strobe |
| wr_ep | input | 4 | Endpoint addressed by set and clear writes |
| set_data | input | 32 | Ones to set |
| clr_data | input | 32 | Ones to clear |
| setup_rx | input | 10 | Per-endpoint SETUP-received strobe |
| rd_ep | input | 4 | Endpoint shown on the mask view |
| rd_view | output | 32 | Mask view of the selected endpoint |
| stall_req | output | 10 | STALL request per endpoint |
| nyet_off | output | 10 | NYET suppression per endpoint |
| dma_pause | output | 10 | DMA pause on interrupt per endpoint |
| tog_pulse | output | 10 | One-cycle data-toggle reset per endpoint |

## Verification
Two kinds of action can hit the same flag in one cycle. The first is a set write together with a clear write to the same bit. The second is a SETUP strobe together with a STALL set write to that endpoint. The bench drives both strobes in the same cycle and then reads the flag outputs and the mask view after the edge. It expects the flag at zero and no toggle pulse. A SETUP strobe on a neighbouring endpoint is also driven, and the bench confirms that it leaves the written endpoint's STALL request in place.

// File: rtl/ep_ctl_pkg.sv
// Shared definitions for the endpoint control bank.
// Assumes the bit positions below are decoded identically by software.
package ep_ctl_pkg;
    localparam int unsigned BIT_STALL = 19;
    localparam int unsigned BIT_TOG   = 18;
    localparam int unsigned BIT_NYET  = 17;
    localparam int unsigned BIT_DMAP  = 16;

    typedef struct packed {
        logic stall;
        logic tog;
        logic nyet;
        logic dmap;
    } ctl_t;

    // Pulls the four control bits out of a data word
    function automatic ctl_t ctl_from_word(input logic [31:0] w);
        ctl_t c;
        c.stall = w[BIT_STALL];
        c.tog   = w[BIT_TOG];
        c.nyet  = w[BIT_NYET];
        c.dmap  = w[BIT_DMAP];
        return c;
    endfunction
endpackage

// File: rtl/ep_ctl_wr_decode.sv
// Turns the shared set/clear strobes and endpoint index into per-endpoint
// enables. Assumes indices at or above NUM_EP address nothing.
module ep_ctl_wr_decode #(
    parameter int unsigned NUM_EP = 10,
    parameter int unsigned EP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [EP_W-1:0]   wr_ep,
    output logic [NUM_EP-1:0] set_en,
    output logic [NUM_EP-1:0] clr_en
);
    logic in_range;

    // Flags an index that names a real endpoint
    always_comb in_range = (32'(wr_ep) < NUM_EP);

    for (genvar e = 0; e < NUM_EP; e++) begin : g_dec
        // One enable per endpoint for each port
        always_comb begin
            set_en[e] = set_we && in_range && (32'(wr_ep) == e);
            clr_en[e] = clr_we && in_range && (32'(wr_ep) == e);
        end
    end

    p_onehot_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_en));
    p_onehot_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_en));
    p_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(wr_ep) >= NUM_EP) |-> (set_en == '0 && clr_en == '0));
endmodule

// File: rtl/ep_ctl_slice.sv
// Control flags of one endpoint. Assumes set_en/clr_en come from the
// decoder and setup_rx is a one-cycle strobe. Clear and SETUP beat set.
module ep_ctl_slice
    import ep_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic clr_en,
    input  ctl_t set_bits,
    input  ctl_t clr_bits,
    input  logic setup_rx,
    output logic stall_q,
    output logic nyet_q,
    output logic dmap_q,
    output logic tog_q
);
    ctl_t s, c;

    // Gates the data bits by their strobes
    always_comb begin
        s = set_en ? set_bits : '0;
        c = clr_en ? clr_bits : '0;
    end

    // Flag registers with clear-over-set priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_q <= 1'b0;
            nyet_q  <= 1'b0;
            dmap_q  <= 1'b0;
            tog_q   <= 1'b0;
        end else begin
            if (c.stall || setup_rx) stall_q <= 1'b0;
            else if (s.stall)        stall_q <= 1'b1;
            if (c.nyet)      nyet_q <= 1'b0;
            else if (s.nyet) nyet_q <= 1'b1;
            if (c.dmap)      dmap_q <= 1'b0;
            else if (s.dmap) dmap_q <= 1'b1;
            tog_q <= s.tog && !c.tog;
        end
    end

    p_setup_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        setup_rx |=> !stall_q);
    p_clr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_bits.nyet) |=> !nyet_q);
    p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en && !setup_rx) |=> $stable(stall_q));
    p_tog_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tog_q |-> $past(set_en && set_bits.tog));
    p_setup_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_rx && !set_en && !clr_en) |=> ($stable(nyet_q) && $stable(dmap_q)));
endmodule

// File: rtl/ep_ctl_bank.sv
// Top of the endpoint control bank: decoder, one slice per endpoint and
// the mask-view read mux. Assumes the mask view is read combinationally.
module ep_ctl_bank
    import ep_ctl_pkg::*;
#(
    parameter int unsigned NUM_EP = 10,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned EP_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [EP_W-1:0]   wr_ep,
    input  logic [DATA_W-1:0] set_data,
    input  logic [DATA_W-1:0] clr_data,
    input  logic [NUM_EP-1:0] setup_rx,
    input  logic [EP_W-1:0]   rd_ep,
    output logic [DATA_W-1:0] rd_view,
    output logic [NUM_EP-1:0] stall_req,
    output logic [NUM_EP-1:0] nyet_off,
    output logic [NUM_EP-1:0] dma_pause,
    output logic [NUM_EP-1:0] tog_pulse
);
    logic [NUM_EP-1:0] set_en, clr_en;
    ctl_t set_bits, clr_bits;

    // Extracts the control fields once for all slices
    always_comb begin
        set_bits = ctl_from_word(32'(set_data));
        clr_bits = ctl_from_word(32'(clr_data));
    end

    ep_ctl_wr_decode #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
        .wr_ep(wr_ep), .set_en(set_en), .clr_en(clr_en)
    );

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        ep_ctl_slice u_slice (
            .clk(clk), .rst_n(rst_n),
            .set_en(set_en[e]), .clr_en(clr_en[e]),
            .set_bits(set_bits), .clr_bits(clr_bits),
            .setup_rx(setup_rx[e]),
            .stall_q(stall_req[e]), .nyet_q(nyet_off[e]),
            .dmap_q(dma_pause[e]), .tog_q(tog_pulse[e])
        );
    end

    // Builds the mask view; toggle reset is never held so reads zero
    always_comb begin
        rd_view = '0;
        if (32'(rd_ep) < NUM_EP) begin
            rd_view[BIT_STALL] = stall_req[rd_ep];
            rd_view[BIT_NYET]  = nyet_off[rd_ep];
            rd_view[BIT_DMAP]  = dma_pause[rd_ep];
        end
    end

    p_oor_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(wr_ep) >= NUM_EP && setup_rx == '0) |=>
        ($stable(stall_req) && $stable(nyet_off) && $stable(dma_pause)));
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_pulse != '0 && !set_we) |=> (tog_pulse == '0));
endmodule

// File: tb/sim_ep_ctl_bank.sv
module sim_ep_ctl_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_we = 1'b0, clr_we = 1'b0;
    logic [3:0]  wr_ep = '0, rd_ep = '0;
    logic [31:0] set_data = '0, clr_data = '0;
    logic [9:0]  setup_rx = '0;
    logic [31:0] rd_view;
    logic [9:0]  stall_req, nyet_off, dma_pause, tog_pulse;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ep_ctl_bank u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives one cycle of strobes, then samples 1 ns after the edge
    task automatic cyc(input bit s, input bit c, input int ep,
                       input logic [31:0] sd, input logic [31:0] cd,
                       input logic [9:0] su);
        @(negedge clk);
        set_we = s; clr_we = c; wr_ep = 4'(ep);
        set_data = sd; clr_data = cd; setup_rx = su;
        @(posedge clk); #1;
        set_we = 0; clr_we = 0; set_data = '0; clr_data = '0; setup_rx = '0;
    endtask

    task automatic t_reset();
        chk("R1 stall", 32'(stall_req), 0);
        chk("R1 nyet", 32'(nyet_off), 0);
        chk("R1 dma", 32'(dma_pause), 0);
        chk("R1 pulse", 32'(tog_pulse), 0);
        for (int e = 0; e < 10; e++) begin
            rd_ep = 4'(e); #1;
            chk("R1 view", rd_view, 0);
        end
    endtask

    task automatic t_stall();
        cyc(1, 0, 3, 32'h0008_0000, 0, 0);
        chk("R2 stall set", 32'(stall_req), 32'h008);
        rd_ep = 3; #1;
        chk("R11 view stall", rd_view, 32'h0008_0000);
        cyc(0, 1, 3, 0, 32'h0008_0000, 0);
        chk("R3 stall clear", 32'(stall_req), 0);
    endtask

    task automatic t_setup();
        cyc(1, 0, 5, 32'h0008_0000, 0, 0);
        cyc(0, 0, 0, 0, 0, 10'h040);
        chk("R4 other ep setup", 32'(stall_req), 32'h020);
        cyc(0, 0, 0, 0, 0, 10'h020);
        chk("R4 setup clears", 32'(stall_req), 0);
        cyc(1, 0, 5, 32'h0008_0000, 0, 10'h020);
        chk("R4 setup beats set", 32'(stall_req), 0);
    endtask

    task automatic t_toggle();
        cyc(1, 0, 2, 32'h0004_0000, 0, 0);
        chk("R5 pulse", 32'(tog_pulse), 32'h004);
        rd_ep = 2; #1;
        chk("R5 view zero", rd_view, 0);
        @(posedge clk); #1;
        chk("R5 pulse ends", 32'(tog_pulse), 0);
        cyc(1, 1, 2, 32'h0004_0000, 32'h0004_0000, 0);
        chk("R8 no pulse", 32'(tog_pulse), 0);
    endtask

    task automatic t_nyet_dma();
        cyc(1, 0, 9, 32'h0002_0000, 0, 0);
        cyc(1, 0, 0, 32'h0001_0000, 0, 0);
        chk("R6 nyet set", 32'(nyet_off), 32'h200);
        chk("R7 dma set", 32'(dma_pause), 32'h001);
        rd_ep = 9; #1;
        chk("R11 view nyet", rd_view, 32'h0002_0000);
        cyc(0, 0, 0, 0, 0, 10'h3FF);
        chk("R12 nyet kept", 32'(nyet_off), 32'h200);
        chk("R12 dma kept", 32'(dma_pause), 32'h001);
        cyc(0, 1, 9, 0, 32'h0002_0000, 0);
        cyc(0, 1, 0, 0, 32'h0001_0000, 0);
        chk("R6 nyet clear", 32'(nyet_off), 0);
        chk("R7 dma clear", 32'(dma_pause), 0);
    endtask

    task automatic t_clr_wins();
        cyc(1, 1, 7, 32'h000F_0000, 32'h000F_0000, 0);
        chk("R8 stall", 32'(stall_req), 0);
        chk("R8 nyet", 32'(nyet_off), 0);
        chk("R8 dma", 32'(dma_pause), 0);
    endtask

    task automatic t_zero_bits();
        cyc(1, 0, 4, 32'hFFF0_FFFF, 0, 0);
        chk("R9 stall", 32'(stall_req), 0);
        chk("R9 nyet", 32'(nyet_off), 0);
        chk("R9 dma", 32'(dma_pause), 0);
        cyc(1, 0, 4, 32'hFFFF_FFFF, 0, 0);
        rd_ep = 4; #1;
        chk("R9 view bits", rd_view, 32'h000B_0000);
        cyc(0, 1, 4, 0, 32'hFFF0_FFFF, 0);
        #1;
        chk("R9 clear other bits", rd_view, 32'h000B_0000);
        cyc(0, 1, 4, 0, 32'h000F_0000, 0);
    endtask

    task automatic t_range();
        cyc(1, 0, 10, 32'h000F_0000, 0, 0);
        chk("R10 idx10 stall", 32'(stall_req), 0);
        chk("R10 idx10 pulse", 32'(tog_pulse), 0);
        cyc(1, 0, 15, 32'h000F_0000, 0, 0);
        chk("R10 idx15 nyet", 32'(nyet_off), 0);
        rd_ep = 15; #1;
        chk("R10 read oor", rd_view, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_stall();
        t_setup();
        t_toggle();
        t_nyet_dma();
        t_clr_wins();
        t_zero_bits();
        t_range();
        finish_run();
    end

    initial begin
        #100000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        finish_run();
    end
endmodule